// File: doc/BRIEF.md
# Dynamic VID Window Monitor

This block watches the seven voltage-identification lines that a processor drives to request a core supply level. On every pulse of a slow sampling tick it latches the lines into a readable VID value register. A run counter tracks how many consecutive samples have returned the same code. Until the code has held for a full run of samples, no supply comparison is made. This keeps a code that is still in transition from raising a false mismatch.

Once the code is settled, the block compares a measured supply code with the target voltage that an external lookup decodes from the VID value. Both codes are unsigned and counted in 6.25 mV units. The allowed deviation is asymmetric. The upper half of an 8-bit limit byte sets the headroom above the target in 25 mV steps, and the lower half sets the margin below the target in 12.5 mV steps.

A deviation sets a sticky status bit and, unless that bit is masked, an alert output. Software clears the condition by strobing a read of the status. The bit then drops once the error is gone.

Top module: `vid_window_monitor`

## Requirements
- R1: On each clock with `sample_tick` high and `mon_en` high, `vid_value` takes the seven pins, with bit i equal to VID line i, on the next edge. While `mon_en` is low, `vid_value` reads 0 and the run of equal samples is forgotten.
- R2: With `vr11_mode` low (the six-line mode, and the default), bit 6 of every captured value is 0. With `vr11_mode` high, all seven lines are captured.
- R3: A comparison is active only after five consecutive samples with the same code. The first sample after reset or enable counts as one. A sample that differs from the previous one restarts the count at one.
- R4: Let `diff` = `meas_code` − `target_code`. When the comparison is active, an error is present if `diff` > 4 × `lim_reg[7:4]` (strictly greater).
- R5: When the comparison is active, an error is also present if `diff` ≤ −2 × `lim_reg[3:0]`.
- R6: With `lim_reg` = 0x00, an active comparison reports an error even when `meas_code` equals `target_code`.
- R7: An error present in a cycle sets `vid_status` at the next clock edge. At the same edge, `vid_alert` becomes the new status value ANDed with the inverse of `status_mask`.
- R8: `vid_status` stays set until a `status_rd` pulse has been seen while it is set and no error is present. A read made while the error persists is remembered, and the bit then clears on the first edge at which the error has gone. A read made while the bit is clear has no effect.
- R9: Synchronous reset clears `vid_value`, `vid_status`, `vid_alert` and the run of equal samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Enables VID capture and comparison |
| vr11_mode | input | 1 | 1 selects seven-line decoding, 0 selects six-line decoding |
| sample_tick | input | 1 | One-cycle sampling strobe |
| vid_pins | input | 7 | VID lines from the processor |
| lim_reg | input | 8 | [7:4] high headroom in 25 mV steps, [3:0] low margin in 12.5 mV steps |
| status_mask | input | 1 | 1 keeps the status bit from driving the alert |
| status_rd | input | 1 | One-cycle pulse marking a status read |
| meas_code | input | 9 | Measured supply code, in 6.25 mV units |
| target_code | input | 9 | Decoded VID target, in 6.25 mV units |
| vid_value | output | 7 | Registered VID value |
| vid_status | output | 1 | Sticky mismatch status |
| vid_alert | output | 1 | Unmasked alert |

## Verification
A capture from the pins reaches `vid_value` one edge after the tick cycle. The run count changes at the same edge, so the comparison becomes active one edge after the fifth equal sample. `vid_status` and `vid_alert` follow one edge after an error appears or after its clearing condition is met. The bench drives all inputs just after the falling edge. A behavioural model updates on the rising edge, and the bench compares all three outputs with it at every falling edge, so each result is checked exactly in the cycle it is due. Directed checks are taken several cycles after each stimulus, once the outputs have settled.

// File: rtl/vidmon_pkg.sv
package vidmon_pkg;
  localparam int VID_LINES = 7;
  localparam int LIM_NIB_W = 4;
  localparam int VOLT_W    = 9;

  typedef struct packed {
    logic [LIM_NIB_W-1:0] hi;
    logic [LIM_NIB_W-1:0] lo;
  } lim_pair_t;
endpackage

// File: rtl/vid_stability_sampler.sv
module vid_stability_sampler #(
  parameter int VID_W          = 7,
  parameter int STABLE_SAMPLES = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wide_mode,
  input  logic             tick,
  input  logic [VID_W-1:0] pins,
  output logic [VID_W-1:0] vid_q,
  output logic             stable
);
  localparam int CNT_W = $clog2(STABLE_SAMPLES + 1);
  localparam logic [CNT_W-1:0] RUN_FULL = CNT_W'(STABLE_SAMPLES);

  logic [VID_W-1:0] keep_bits;
  logic [VID_W-1:0] sample;
  logic [CNT_W-1:0] run_cnt;

  always_comb begin
    keep_bits = '1;
    if (!wide_mode) keep_bits[VID_W-1] = 1'b0;
    sample = pins & keep_bits;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      vid_q   <= '0;
      run_cnt <= '0;
    end else if (tick) begin
      vid_q <= sample;
      if (run_cnt == '0 || sample != vid_q)
        run_cnt <= CNT_W'(1);
      else if (run_cnt != RUN_FULL)
        run_cnt <= run_cnt + 1'b1;
    end
  end

  assign stable = (run_cnt == RUN_FULL);
endmodule

// File: rtl/vid_window_check.sv
module vid_window_check #(
  parameter int V_W      = 9,
  parameter int NIB_W    = 4,
  parameter int HI_SHIFT = 2,
  parameter int LO_SHIFT = 1
) (
  input  logic [V_W-1:0]   meas,
  input  logic [V_W-1:0]   target,
  input  logic [NIB_W-1:0] lim_hi,
  input  logic [NIB_W-1:0] lim_lo,
  output logic             outside
);
  localparam int LIM_BITS = NIB_W + ((HI_SHIFT > LO_SHIFT) ? HI_SHIFT : LO_SHIFT);
  localparam int D_W      = ((V_W > LIM_BITS) ? V_W : LIM_BITS) + 2;

  logic signed [D_W-1:0] diff;
  logic signed [D_W-1:0] hi_units;
  logic signed [D_W-1:0] lo_units;

  always_comb begin
    diff     = $signed(D_W'(meas)) - $signed(D_W'(target));
    hi_units = $signed(D_W'(lim_hi) << HI_SHIFT);
    lo_units = $signed(D_W'(lim_lo) << LO_SHIFT);
    outside  = (diff > hi_units) || (diff <= -lo_units);
  end
endmodule

// File: rtl/vid_status_latch.sv
module vid_status_latch (
  input  logic clk,
  input  logic rst,
  input  logic err,
  input  logic rd,
  input  logic mask,
  output logic status_q,
  output logic alert_q
);
  logic rd_seen;
  logic st_nx;

  assign st_nx = err | (status_q & ~(rd_seen | rd));

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      alert_q  <= 1'b0;
      rd_seen  <= 1'b0;
    end else begin
      status_q <= st_nx;
      alert_q  <= st_nx & ~mask;
      rd_seen  <= st_nx & (rd_seen | (rd & status_q));
    end
  end
endmodule

// File: rtl/vid_window_monitor.sv
module vid_window_monitor
  import vidmon_pkg::*;
#(
  parameter int VID_W          = VID_LINES,
  parameter int NIB_W          = LIM_NIB_W,
  parameter int V_W            = VOLT_W,
  parameter int STABLE_SAMPLES = 5,
  parameter int HI_SHIFT       = 2,
  parameter int LO_SHIFT       = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mon_en,
  input  logic               vr11_mode,
  input  logic               sample_tick,
  input  logic [VID_W-1:0]   vid_pins,
  input  logic [2*NIB_W-1:0] lim_reg,
  input  logic               status_mask,
  input  logic               status_rd,
  input  logic [V_W-1:0]     meas_code,
  input  logic [V_W-1:0]     target_code,
  output logic [VID_W-1:0]   vid_value,
  output logic               vid_status,
  output logic               vid_alert
);
  logic code_stable;
  logic outside;
  logic cmp_err;

  vid_stability_sampler #(.VID_W(VID_W), .STABLE_SAMPLES(STABLE_SAMPLES)) u_sampler (
    .clk(clk), .rst(rst), .en(mon_en), .wide_mode(vr11_mode), .tick(sample_tick),
    .pins(vid_pins), .vid_q(vid_value), .stable(code_stable)
  );

  vid_window_check #(.V_W(V_W), .NIB_W(NIB_W), .HI_SHIFT(HI_SHIFT), .LO_SHIFT(LO_SHIFT)) u_window (
    .meas(meas_code), .target(target_code),
    .lim_hi(lim_reg[2*NIB_W-1:NIB_W]), .lim_lo(lim_reg[NIB_W-1:0]),
    .outside(outside)
  );

  assign cmp_err = code_stable & mon_en & outside;

  vid_status_latch u_status (
    .clk(clk), .rst(rst), .err(cmp_err), .rd(status_rd), .mask(status_mask),
    .status_q(vid_status), .alert_q(vid_alert)
  );
endmodule

// File: rtl/vid_window_monitor_chk.sv
module vid_window_monitor_chk #(
  parameter int VID_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             mon_en,
  input logic             vr11_mode,
  input logic             sample_tick,
  input logic             status_rd,
  input logic             status_mask,
  input logic             code_stable,
  input logic [VID_W-1:0] vid_value,
  input logic             vid_status,
  input logic             vid_alert
);
  logic read_flag;

  always_ff @(posedge clk) begin
    if (rst || !vid_status) read_flag <= 1'b0;
    else if (status_rd)     read_flag <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!vid_status && !vid_alert && vid_value == '0)); // R9
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !mon_en |=> (vid_value == '0)); // R1
  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sample_tick && mon_en && !vr11_mode) |=> !vid_value[VID_W-1]); // R2
  AST_SET_NEEDS_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(vid_status) |-> $past(code_stable && mon_en)); // R3
  AST_ALERT_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
    vid_alert |-> vid_status); // R7
  AST_MASK_BLOCKS_ALERT: assert property (@(posedge clk) disable iff (rst)
    status_mask |=> !vid_alert); // R7
  AST_CLEAR_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $fell(vid_status) |-> $past(read_flag || status_rd)); // R8
endmodule

bind vid_window_monitor vid_window_monitor_chk #(.VID_W(VID_W)) u_chk (
  .clk(clk), .rst(rst), .mon_en(mon_en), .vr11_mode(vr11_mode),
  .sample_tick(sample_tick), .status_rd(status_rd), .status_mask(status_mask),
  .code_stable(code_stable), .vid_value(vid_value),
  .vid_status(vid_status), .vid_alert(vid_alert)
);

// File: tb/vid_window_monitor_bench.sv
module vid_window_monitor_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mon_en = 1'b0;
  logic       vr11_mode = 1'b0;
  logic       sample_tick = 1'b0;
  logic [6:0] vid_pins = '0;
  logic [7:0] lim_reg = '0;
  logic       status_mask = 1'b0;
  logic       status_rd = 1'b0;
  logic [8:0] meas_code = '0;
  logic [8:0] target_code = '0;
  logic [6:0] vid_value;
  logic       vid_status;
  logic       vid_alert;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  int m_vid = 0, m_run = 0, m_st = 0, m_rs = 0, m_al = 0;
  int m_diff, m_err, m_nst, m_smp;

  always #5 clk = ~clk;

  vid_window_monitor u_vid_window_monitor (
    .clk(clk), .rst(rst), .mon_en(mon_en), .vr11_mode(vr11_mode),
    .sample_tick(sample_tick), .vid_pins(vid_pins), .lim_reg(lim_reg),
    .status_mask(status_mask), .status_rd(status_rd), .meas_code(meas_code),
    .target_code(target_code), .vid_value(vid_value), .vid_status(vid_status),
    .vid_alert(vid_alert)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_vid = 0; m_run = 0; m_st = 0; m_rs = 0; m_al = 0;
    end else begin
      m_diff = int'(meas_code) - int'(target_code);
      m_err  = (m_run == 5 && mon_en &&
                (m_diff > 4 * int'(lim_reg[7:4]) || m_diff <= -2 * int'(lim_reg[3:0]))) ? 1 : 0;
      m_nst  = (m_err != 0 || (m_st != 0 && m_rs == 0 && !status_rd)) ? 1 : 0;
      m_rs   = (m_nst != 0 && (m_rs != 0 || (status_rd && m_st != 0))) ? 1 : 0;
      m_st   = m_nst;
      m_al   = (m_nst != 0 && !status_mask) ? 1 : 0;
      if (!mon_en) begin
        m_vid = 0; m_run = 0;
      end else if (sample_tick) begin
        m_smp = vr11_mode ? int'(vid_pins) : int'(vid_pins) % 64;
        if (m_run == 0 || m_smp != m_vid) m_run = 1;
        else if (m_run < 5) m_run = m_run + 1;
        m_vid = m_smp;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R1 vid_value vs model", int'(vid_value), m_vid);
      check("R8 vid_status vs model", int'(vid_status), m_st);
      check("R7 vid_alert vs model", int'(vid_alert), m_al);
      cyc++;
      sample_tick = (cyc % 4 == 0);
      status_rd = 1'b0;
    end
  endtask

  task automatic read_status();
    status_rd = 1'b1;
    step(1);
  endtask

  initial begin
    step(3);
    check("R9 reset vid_value", int'(vid_value), 0);
    check("R9 reset status", int'(vid_status), 0);
    check("R9 reset alert", int'(vid_alert), 0);
    rst = 1'b0;
    target_code = 9'd160;
    meas_code = 9'd160;
    lim_reg = 8'h44;
    vid_pins = 7'h7F;
    mon_en = 1'b1;
    step(30);
    check("R2 six-line mode drops bit 6", int'(vid_value), 8'h3F);
    check("R4 in window", int'(vid_status), 0);
    meas_code = 9'd176; step(4);
    check("R4 diff equal to high limit passes", int'(vid_status), 0);
    meas_code = 9'd177; step(3);
    check("R4 diff above high limit", int'(vid_status), 1);
    check("R7 alert unmasked", int'(vid_alert), 1);
    read_status(); step(3);
    check("R8 read while error persists", int'(vid_status), 1);
    meas_code = 9'd160; step(2);
    check("R8 cleared after earlier read", int'(vid_status), 0);
    meas_code = 9'd153; step(4);
    check("R5 diff above low limit passes", int'(vid_status), 0);
    meas_code = 9'd152; step(3);
    check("R5 diff at low limit", int'(vid_status), 1);
    meas_code = 9'd160; step(4);
    check("R8 no clear without read", int'(vid_status), 1);
    read_status(); step(2);
    check("R5 cleared", int'(vid_status), 0);
    read_status(); step(2);
    status_mask = 1'b1; meas_code = 9'd100; step(3);
    check("R7 masked status", int'(vid_status), 1);
    check("R7 masked alert", int'(vid_alert), 0);
    status_mask = 1'b0; step(2);
    check("R7 unmasked alert", int'(vid_alert), 1);
    meas_code = 9'd160; read_status(); step(2);
    check("R8 cleared after mask test", int'(vid_status), 0);
    lim_reg = 8'h00; step(3);
    check("R6 zero limits always error", int'(vid_status), 1);
    lim_reg = 8'h44; read_status(); step(2);
    check("R6 cleared after limits restored", int'(vid_status), 0);
    vid_pins = 7'h15; step(5);
    meas_code = 9'd300; step(8);
    check("R3 no compare during new run", int'(vid_status), 0);
    step(20);
    check("R3 compare after five equal samples", int'(vid_status), 1);
    meas_code = 9'd160; read_status(); step(2);
    vr11_mode = 1'b1; vid_pins = 7'h55; step(6);
    check("R1 seven-line capture", int'(vid_value), 8'h55);
    vr11_mode = 1'b0; step(6);
    check("R2 bit 6 dropped again", int'(vid_value), 8'h15);
    mon_en = 1'b0; step(2);
    check("R1 disabled reads zero", int'(vid_value), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule